// File: doc/BRIEF.md
# Two-Wire Target Register Write Port

This block is the target side of an I2C bus. It accepts write transactions into a bank of 8-bit control registers and shows their contents as parallel outputs. The block runs on a system clock and samples SCL and SDA through synchronizer flops. It detects start and stop conditions and compares the seven address bits of the first byte against its own device address. It then takes a pointer byte, followed by any number of data bytes. Each data byte goes into the register the pointer selects, and the pointer then moves on to the next register.

Each accepted byte is acknowledged by pulling SDA low for the ninth clock. The SDA line is open-drain, so the block only ever drives it low. It releases the line for any transaction that is not its own and for any read request. The register outputs are plain levels. They have no valid/ready handshake and no back-pressure, because a register only changes when a write byte completes on the bus. The pointer wraps after the last implemented register, so a long burst overwrites the registers at the start of the bank.

Top module: `i2c_reg_write_port`

## Requirements
- R1: After reset every register output is 0x00 and SDA is released (`sda_pull_o` = 0).
- R2: A first byte whose upper seven bits equal `DEV_ADDR` and whose bit 0 (direction) is 0 is acknowledged. `sda_pull_o` is high from the SCL fall after the eighth bit until the SCL fall after the ninth clock.
- R3: On an address mismatch, or when the direction bit is 1, no byte is acknowledged and no register changes until the next start condition.
- R4: The second byte sets the register pointer from its bits 4..0. Bits 7..5 are ignored. The byte is acknowledged.
- R5: Data bytes are received MSB first. Each one is acknowledged and stored into the register the pointer selects.
- R6: After each data byte the pointer increments by one, so a burst fills consecutive registers.
- R7: After a data byte at pointer `LAST_REG` (0x1C), the pointer becomes 0x00 and the next byte overwrites register 0.
- R8: A pointer of 0x1D to 0x1F selects no register. A data byte sent there is acknowledged but not stored, and the pointer then becomes 0x00.
- R9: A stop or start condition that arrives before all eight bits of a data byte are received discards that byte. No register changes.
- R10: A repeated start returns reception to the address phase, and a new pointer byte follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| regs_o | output | (LAST_REG+1)*8 | Register contents, register k in bits [8k+7:8k] |

## Verification
The bench overrides `DEV_ADDR` to 0x5C. This makes a mismatched address with a single differing bit easy to drive. It keeps `LAST_REG` at 28 with a 5-bit pointer, so the wrap from 0x1C and the three unimplemented pointer values 0x1D to 0x1F can all be reached in short bursts. A bus quarter-period of eight system clocks leaves room for the synchronizer delay, so every edge and condition is seen cleanly. Expected register writes come from a bench model of the pointer and pass through a scoreboard queue. This means a dropped, misplaced or extra write shows up as a mismatch.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2cw_bus_sense.sv
module i2cw_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_byte_engine.sv
module i2cw_byte_engine
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         PTR_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             ptr_load,
  output logic [PTR_W-1:0] ptr_val,
  output logic             wr_en,
  output logic [7:0]       wr_data
);
  phase_e     ph;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       ack_q, in_ack;
  logic       active, byte_done;

  assign active    = (ph == PH_ADDR) || (ph == PH_PTR) || (ph == PH_DATA);
  assign byte_done = active && scl_fall && (cnt == 4'd8) && !in_ack
                     && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ack_q  <= 1'b0;
      in_ack <= 1'b0;
    end else if (start_det) begin
      ph     <= PH_ADDR;
      cnt    <= '0;
      ack_q  <= 1'b0;
      in_ack <= 1'b0;
    end else if (stop_det) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      ack_q  <= 1'b0;
      in_ack <= 1'b0;
    end else if (active) begin
      if (scl_rise && !in_ack && cnt != 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (scl_fall && in_ack) begin
        ack_q  <= 1'b0;
        in_ack <= 1'b0;
        cnt    <= '0;
        if (ph == PH_ADDR)     ph <= PH_PTR;
        else if (ph == PH_PTR) ph <= PH_DATA;
      end else if (byte_done) begin
        in_ack <= 1'b1;
        if (ph == PH_ADDR && (sh[7:1] != DEV_ADDR || sh[0])) ph <= PH_SKIP;
        else ack_q <= 1'b1;
      end
    end
  end

  assign sda_pull = ack_q;
  assign ptr_load = byte_done && (ph == PH_PTR);
  assign ptr_val  = sh[PTR_W-1:0];
  assign wr_en    = byte_done && (ph == PH_DATA);
  assign wr_data  = sh;

  // R2
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(scl_fall));
  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SKIP) |-> !ack_q);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (ph == PH_ADDR) && (cnt == 4'd0) && !ack_q);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (ph == PH_IDLE) && !ack_q);
endmodule

// File: rtl/i2cw_reg_bank.sv
module i2cw_reg_bank #(
  parameter int PTR_W    = 5,
  parameter int LAST_REG = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ptr_load,
  input  logic [PTR_W-1:0]        ptr_val,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  output logic [(LAST_REG+1)*8-1:0] regs_flat
);
  localparam int               NREG   = LAST_REG + 1;
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_REG);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (ptr_load) ptr <= ptr_val;
    else if (wr_en) ptr <= (ptr >= LAST_P) ? '0 : ptr + 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else if (wr_en && ptr == PTR_W'(g)) r_q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = r_q;
  end

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && ptr < LAST_P) |=> ptr == $past(ptr) + 1'b1);
  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && ptr >= LAST_P) |=> ptr == '0);
  // R5
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
  // R8
  dead_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr > LAST_P) |=> $stable(regs_flat));
endmodule

// File: rtl/i2c_reg_write_port.sv
module i2c_reg_write_port #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         LAST_REG    = 28,
  parameter int         PTR_W       = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_pull_o,
  output logic [(LAST_REG+1)*8-1:0] regs_o
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             ptr_load, wr_en;
  logic [PTR_W-1:0] ptr_val;
  logic [7:0]       wr_data;

  i2cw_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2cw_byte_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull_o), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_en(wr_en), .wr_data(wr_data));

  i2cw_reg_bank #(.PTR_W(PTR_W), .LAST_REG(LAST_REG)) u_bank (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_en(wr_en), .wr_data(wr_data), .regs_flat(regs_o));

  // R1
  rst_release_chk: assert property (@(posedge clk)
    !rst_n |=> !sda_pull_o);
endmodule

// File: tb/tb_i2c_reg_write_port.sv
module tb_i2c_reg_write_port;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 8;
  localparam logic [6:0] ADDR       = 7'h5C;
  localparam int         LASTR      = 28;
  localparam int         NREG       = LASTR + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  wire  sda_bus = sda_m & ~sda_pull;

  int errors = 0, checks = 0;
  logic [12:0] exp_q[$];
  logic [7:0]  model [NREG];
  int          mptr = 0;
  logic [7:0]  seed = 8'h13;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_write_port #(.DEV_ADDR(ADDR), .LAST_REG(LASTR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .regs_o(regs));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = sda_pull; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic ctl_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    send_byte(b, a);
    chk(a == exp_ack, tag, a, exp_ack);
  endtask

  // data byte into an addressed (live) transaction; model tracks the pointer
  task automatic data_byte(input string tag);
    logic a;
    seed = seed + 8'd37;
    if (mptr <= LASTR) begin
      if (model[mptr] != seed) exp_q.push_back({5'(mptr), seed});
      model[mptr] = seed;
    end
    mptr = (mptr >= LASTR) ? 0 : mptr + 1;
    send_byte(seed, a);
    chk(a == 1'b1, tag, a, 1);
  endtask

  task automatic open_write(input logic [7:0] p);
    bus_start();
    ctl_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    ctl_byte(p, 1'b1, "R4 pointer ack");
    mptr = int'(p[4:0]);
  endtask

  // scoreboard monitor
  initial begin
    logic [NREG*8-1:0] prev;
    @(posedge rst_n); @(negedge clk);
    prev = regs;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NREG; i++) begin
        if (regs[i*8 +: 8] != prev[i*8 +: 8]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R8/R9 unexpected write", i, -1);
          end else begin
            logic [12:0] e;
            e = exp_q.pop_front();
            chk(i == int'(e[12:8]) && regs[i*8 +: 8] == e[7:0],
                "R5/R6/R7 write order", {i[4:0], regs[i*8 +: 8]}, e);
          end
        end
      end
      prev = regs;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(regs == '0, "R1 regs zero", 0, 0);
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5 R6 basic burst
    open_write(8'h03);
    repeat (3) data_byte("R5 data ack");
    bus_stop();

    // R3 mismatched address: one bit differs
    bus_start();
    ctl_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, "R3 mismatch no ack");
    ctl_byte(8'h02, 1'b0, "R3 pointer ignored");
    ctl_byte(8'hEE, 1'b0, "R3 data ignored");
    bus_stop();

    // R3 read request
    bus_start();
    ctl_byte({ADDR, 1'b1}, 1'b0, "R3 read no ack");
    ctl_byte(8'h77, 1'b0, "R3 read data ignored");
    bus_stop();

    // R4 upper pointer bits ignored
    open_write(8'hE5);
    data_byte("R4 data ack");
    bus_stop();

    // R7 wrap from 0x1C
    open_write(8'h1B);
    repeat (4) data_byte("R7 wrap ack");
    bus_stop();

    // R8 dead pointer slot
    open_write(8'h1E);
    data_byte("R8 dead slot ack");
    data_byte("R8 after dead slot");
    bus_stop();

    // R9 partial byte then stop
    open_write(8'h0A);
    send_bits(8'hA5, 4);
    bus_stop();

    // R9 + R10: partial byte then repeated start
    open_write(8'h0B);
    data_byte("R10 before restart");
    send_bits(8'h5A, 5);
    bus_start();
    ctl_byte({ADDR, 1'b0}, 1'b1, "R10 readdressed");
    ctl_byte(8'h10, 1'b1, "R10 new pointer");
    mptr = 16;
    repeat (2) data_byte("R10 data");
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == model[i], "R5 final contents", regs[i*8 +: 8], model[i]);
    chk(sda_pull == 1'b0, "R2 released when idle", sda_pull, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule